// File: doc/BRIEF.md
# Display Control Word Register

This block sits between a host bus and a character display engine. It watches active-low chip-enable, write and read strobes, a memory-select line and two address bits. When a host cycle targets the control word it stores the byte or returns it. The stored byte drives the display engine through separate outputs: a brightness code, a flash enable and a blink enable. Two bits of the byte are commands, not stored levels. One starts a self test. The other starts a wipe of the display memories.

Each write sets every field at once. The brightness code passes through as stored, with 0 as the brightest level and all-ones as a blank display. Setting the test bit raises a one-cycle start pulse and marks the test as busy. The external test engine later reports done and a pass flag, and that flag becomes the result bit. Setting the wipe bit raises a one-cycle clear pulse and is not stored.

Top module: `ctlw_core`

## Requirements
- R1: A write takes effect only when ce_n=0, wr_n=0, rd_n=1, sel=1, a4=1 and a3=0. Fields and pulses appear in the cycle after the clock edge that first samples the write.
- R2: A read cycle (ce_n=0, wr_n=1, rd_n=0, sel=1, a4=1, a3=0) puts the word on rd_data in the cycle after it is sampled. The word is laid out as bit7=0, bit6=busy, bit5=result, bit4=blink, bit3=flash, bits2..0=brightness. At all other times rd_data is 0.
- R3: A cycle with ce_n=1, with wr_n and rd_n equal, or with any other sel/a4/a3 pattern changes no field, raises no pulse and returns 0 on rd_data.
- R4: A write loads bright from bits 2..0, flash_en from bit 3 and blink_en from bit 4, all together.
- R5: A write with bit 6 set raises test_start for exactly one cycle. Bit 6 then reads 1 and the result bit reads 0 until the test ends.
- R6: A write with bit 6 clear leaves the result bit unchanged, whatever bit 5 holds.
- R7: When test_done is high while a test is busy, busy clears and the result bit takes test_pass. test_done while idle changes nothing.
- R8: A write with bit 7 set raises clear_pulse for exactly one cycle. Bit 7 always reads back as 0.
- R9: A write strobe held low for several cycles acts only once.
- R10: After reset the word reads 0x00, with bright=0, flash and blink off, and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| sel | input | 1 | Memory select; 1 selects the register space |
| a4 | input | 1 | Address bit 4 |
| a3 | input | 1 | Address bit 3 |
| wr_data | input | 8 | Host write data |
| test_done | input | 1 | Self-test engine finished |
| test_pass | input | 1 | Self-test outcome, 1 = passed |
| bright | output | 3 | Brightness code |
| flash_en | output | 1 | Per-character flash enable |
| blink_en | output | 1 | Whole-display blink enable |
| clear_pulse | output | 1 | One-cycle memory wipe command |
| test_start | output | 1 | One-cycle self-test start |
| rd_data | output | 8 | Read-back word |

## Verification
The bench drives both illegal strobe pairs with data 0xFF, plus writes with the wrong select or address bits. A decoder that acts on only one strobe would load the brightness or fire a wipe on these cycles. It writes bit 5 with bit 6 clear, both after a passed test and after a failed one, which catches a design that stores bit 5 directly. It holds a wipe write for three cycles to show that a level-triggered decoder emits repeated pulses. It also sends test_done while no test is running, which a design that fails to gate on busy would accept as a result.

// File: rtl/ctlw_pkg.sv
package ctlw_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE    = 2'd0,
      BUS_WRITE   = 2'd1,
      BUS_READ    = 2'd2,
      BUS_ILLEGAL = 2'd3
   } bus_op_e;

   function automatic bus_op_e classify(input logic ce_n, input logic wr_n, input logic rd_n);
      if (ce_n)
         return BUS_IDLE;
      case ({wr_n, rd_n})
         2'b01:   return BUS_WRITE;
         2'b10:   return BUS_READ;
         default: return BUS_ILLEGAL;
      endcase
   endfunction
endpackage

// File: rtl/ctlw_decode.sv
module ctlw_decode
   import ctlw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic wr_n,
   input  logic rd_n,
   input  logic sel,
   input  logic a4,
   input  logic a3,
   output logic wr_go,
   output logic rd_sel
);
   bus_op_e op;
   logic    addr_hit;
   logic    wr_lvl;
   logic    wr_lvl_q;

   assign op       = classify(ce_n, wr_n, rd_n);
   assign addr_hit = sel & a4 & ~a3;
   assign wr_lvl   = (op == BUS_WRITE) && addr_hit;
   assign rd_sel   = (op == BUS_READ) && addr_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_lvl_q <= 1'b0;
      else
         wr_lvl_q <= wr_lvl;
   end

   assign wr_go = wr_lvl & ~wr_lvl_q;
endmodule

// File: rtl/ctlw_regs.sv
module ctlw_regs #(
   parameter int DATA_W   = 8,
   parameter int BRIGHT_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_go,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                test_done,
   input  logic                test_pass,
   output logic [BRIGHT_W-1:0] bright,
   output logic                flash_en,
   output logic                blink_en,
   output logic                clear_pulse,
   output logic                test_start,
   output logic                test_busy,
   output logic [DATA_W-1:0]   word
);
   localparam int FLASH_B = BRIGHT_W;
   localparam int BLINK_B = BRIGHT_W + 1;
   localparam int PASS_B  = BRIGHT_W + 2;
   localparam int BUSY_B  = BRIGHT_W + 3;
   localparam int CLR_B   = BRIGHT_W + 4;

   logic test_ok;
   logic unused_pass_bit;

   // the result bit is owned by the test engine; the host value is dropped
   assign unused_pass_bit = wr_data[PASS_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bright      <= '0;
         flash_en    <= 1'b0;
         blink_en    <= 1'b0;
         clear_pulse <= 1'b0;
         test_start  <= 1'b0;
         test_busy   <= 1'b0;
         test_ok     <= 1'b0;
      end else begin
         clear_pulse <= wr_go & wr_data[CLR_B];
         test_start  <= wr_go & wr_data[BUSY_B];
         if (wr_go) begin
            bright   <= wr_data[BRIGHT_W-1:0];
            flash_en <= wr_data[FLASH_B];
            blink_en <= wr_data[BLINK_B];
         end
         // a new start outranks a completion arriving in the same cycle
         if (wr_go && wr_data[BUSY_B]) begin
            test_busy <= 1'b1;
            test_ok   <= 1'b0;
         end else if (test_busy && test_done) begin
            test_busy <= 1'b0;
            test_ok   <= test_pass;
         end
      end
   end

   assign word = {1'b0, test_busy, test_ok, blink_en, flash_en, bright};
endmodule

// File: rtl/ctlw_rdport.sv
module ctlw_rdport #(
   parameter int DATA_W = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_sel,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rd_data
);
   if (RD_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_data <= '0;
         else
            rd_data <= rd_sel ? word : '0;
      end
   end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign rd_data = rd_sel ? word : '0;
   end
endmodule

// File: rtl/ctlw_core.sv
module ctlw_core #(
   parameter int DATA_W   = 8,
   parameter int BRIGHT_W = 3,
   parameter bit RD_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ce_n,
   input  logic                wr_n,
   input  logic                rd_n,
   input  logic                sel,
   input  logic                a4,
   input  logic                a3,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic                test_done,
   input  logic                test_pass,
   output logic [BRIGHT_W-1:0] bright,
   output logic                flash_en,
   output logic                blink_en,
   output logic                clear_pulse,
   output logic                test_start,
   output logic [DATA_W-1:0]   rd_data
);
   if (DATA_W != BRIGHT_W + 5) begin : g_bad_width
      $error("ctlw_core: DATA_W must equal BRIGHT_W + 5");
   end
   if (BRIGHT_W < 1) begin : g_bad_bright
      $error("ctlw_core: BRIGHT_W must be at least 1");
   end

   logic              wr_go;
   logic              rd_sel;
   logic              test_busy;
   logic [DATA_W-1:0] word;

   ctlw_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .ce_n   (ce_n),
      .wr_n   (wr_n),
      .rd_n   (rd_n),
      .sel    (sel),
      .a4     (a4),
      .a3     (a3),
      .wr_go  (wr_go),
      .rd_sel (rd_sel)
   );

   ctlw_regs #(.DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_go       (wr_go),
      .wr_data     (wr_data),
      .test_done   (test_done),
      .test_pass   (test_pass),
      .bright      (bright),
      .flash_en    (flash_en),
      .blink_en    (blink_en),
      .clear_pulse (clear_pulse),
      .test_start  (test_start),
      .test_busy   (test_busy),
      .word        (word)
   );

   ctlw_rdport #(.DATA_W(DATA_W), .RD_REG(RD_REG)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_sel  (rd_sel),
      .word    (word),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/ctlw_chk.sv
module ctlw_chk #(
   parameter int DATA_W   = 8,
   parameter int BRIGHT_W = 3,
   parameter bit RD_REG   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ce_n,
   input logic                wr_n,
   input logic                rd_n,
   input logic                start_bit,
   input logic                test_done,
   input logic [BRIGHT_W-1:0] bright,
   input logic                flash_en,
   input logic                blink_en,
   input logic                clear_pulse,
   input logic                test_start,
   input logic [DATA_W-1:0]   rd_data,
   input logic                test_busy,
   input logic                wr_go
);
   // R8: the wipe command never lasts two cycles
   p_clear_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear_pulse |=> !clear_pulse);

   // R5: start is one cycle wide and coincides with the busy flag
   p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |=> !test_start);
   p_start_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      test_start |-> test_busy);

   // R3: idle or illegal strobe pairs leave every control output alone
   p_no_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || (wr_n == rd_n)) |=>
         ($stable(bright) && $stable(flash_en) && $stable(blink_en)
          && !clear_pulse && !test_start));

   // R7: completion ends a running test unless a restart arrives with it
   p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (test_busy && test_done && !(wr_go && start_bit)) |=> !test_busy);

   if (RD_REG) begin : g_rd_chk
      // R2: the read bus stays zero outside read cycles
      p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !(!ce_n && wr_n && !rd_n) |=> (rd_data == '0));
   end
endmodule

bind ctlw_core ctlw_chk #(.DATA_W(DATA_W), .BRIGHT_W(BRIGHT_W), .RD_REG(RD_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n        (ce_n),
   .wr_n        (wr_n),
   .rd_n        (rd_n),
   .start_bit   (wr_data[BRIGHT_W+3]),
   .test_done   (test_done),
   .bright      (bright),
   .flash_en    (flash_en),
   .blink_en    (blink_en),
   .clear_pulse (clear_pulse),
   .test_start  (test_start),
   .rd_data     (rd_data),
   .test_busy   (test_busy),
   .wr_go       (wr_go)
);

// File: tb/tb_ctlw_core.sv
module tb_ctlw_core;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic       sel = 1'b0, a4 = 1'b0, a3 = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       test_done = 1'b0, test_pass = 1'b0;
   logic [2:0] bright;
   logic       flash_en, blink_en, clear_pulse, test_start;
   logic [7:0] rd_data;

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;

   // expected snapshot: {bright[2:0], flash, blink, clear, start, rd_data[7:0]}
   int          q_due[$];
   logic [14:0] q_exp[$];
   string       q_req[$];

   // reference state built from the requirements
   logic [2:0] m_bright = 3'd0;
   logic       m_flash = 1'b0, m_blink = 1'b0, m_busy = 1'b0, m_pass = 1'b0;

   ctlw_core dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
      .sel(sel), .a4(a4), .a3(a3), .wr_data(wr_data),
      .test_done(test_done), .test_pass(test_pass),
      .bright(bright), .flash_en(flash_en), .blink_en(blink_en),
      .clear_pulse(clear_pulse), .test_start(test_start), .rd_data(rd_data)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] m_word();
      return {1'b0, m_busy, m_pass, m_blink, m_flash, m_bright};
   endfunction

   task automatic push(input logic clr, input logic st, input logic [7:0] rd, input string req);
      q_due.push_back(cyc + 1);
      q_exp.push_back({m_bright, m_flash, m_blink, clr, st, rd});
      q_req.push_back(req);
   endtask

   // monitor: compare every due item against the outputs
   always @(negedge clk) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
         int          due;
         logic [14:0] exp;
         logic [14:0] act;
         string       req;
         due = q_due.pop_front();
         exp = q_exp.pop_front();
         req = q_req.pop_front();
         act = {bright, flash_en, blink_en, clear_pulse, test_start, rd_data};
         n_chk++;
         if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, due, act, exp);
         end
      end
   end

   // one bus cycle held for 'hold' clocks, then released
   task automatic bus(input logic c, input logic w, input logic r,
                      input logic s, input logic b4, input logic b3,
                      input logic [7:0] d, input int hold, input string req);
      logic hit, wr_hit, rd_hit;
      hit    = s & b4 & ~b3;
      wr_hit = !c && !w && r && hit;
      rd_hit = !c && w && !r && hit;
      ce_n = c; wr_n = w; rd_n = r; sel = s; a4 = b4; a3 = b3; wr_data = d;
      if (wr_hit) begin
         m_bright = d[2:0];
         m_flash  = d[3];
         m_blink  = d[4];
         if (d[6]) begin
            m_busy = 1'b1;
            m_pass = 1'b0;
         end
      end
      for (int i = 0; i < hold; i++) begin
         if (i == 0)
            push(wr_hit & d[7], wr_hit & d[6], rd_hit ? m_word() : 8'h00, req);
         else
            push(1'b0, 1'b0, rd_hit ? m_word() : 8'h00, req);
         @(negedge clk);
      end
      ce_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; wr_data = 8'h00;
      push(1'b0, 1'b0, 8'h00, req);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d, input string req);
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, d, 1, req);
   endtask

   task automatic rd(input string req);
      bus(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1, req);
   endtask

   task automatic done(input logic p, input string req);
      test_done = 1'b1; test_pass = p;
      if (m_busy) begin
         m_busy = 1'b0;
         m_pass = p;
      end
      push(1'b0, 1'b0, 8'h00, req);
      @(negedge clk);
      test_done = 1'b0; test_pass = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push(1'b0, 1'b0, 8'h00, "R10 reset state");
      @(negedge clk);
      rd("R10 reset word 0x00");

      wr(8'h1D, "R1 R4 write fields");
      rd("R2 read back 0x1D");
      wr(8'h07, "R4 blank code 111");
      rd("R2 read back 0x07");
      wr(8'h00, "R4 max brightness code 000");
      wr(8'h0A, "R4 flash only");

      bus(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hD3, 1, "R3 sel low write");
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hD3, 1, "R3 a4 low write");
      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hD3, 1, "R3 a3 high write");
      bus(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hD3, 1, "R3 chip disabled");
      bus(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 1, "R3 both strobes low");
      bus(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 1, "R3 both strobes high");
      bus(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1, "R3 read wrong select");
      rd("R3 word unchanged 0x0A");

      wr(8'h40, "R5 start test");
      rd("R5 busy reads 0x40");
      done(1'b1, "R7 done pass");
      rd("R7 result 0x20");
      wr(8'h00, "R6 bit5 write 0 ignored");
      rd("R6 result kept 0x20");
      wr(8'h60, "R5 restart clears result");
      rd("R5 busy 0x40");
      done(1'b0, "R7 done fail");
      rd("R7 result 0x00");
      wr(8'h20, "R6 bit5 write 1 ignored");
      rd("R6 result kept 0x00");
      done(1'b1, "R7 done while idle");
      rd("R7 idle done ignored");

      wr(8'h80, "R8 clear pulse");
      rd("R8 bit7 reads 0");
      wr(8'h95, "R8 clear with fields");
      rd("R8 read 0x15");

      bus(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'hC2, 3, "R9 held write one action");
      rd("R9 word after held write");
      done(1'b1, "R7 finish");
      rd("R7 final word");

      repeat (2) @(negedge clk);
      if (q_due.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R2 scoreboard: actual=%0d pending expected=0", q_due.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule